// File: doc/BRIEF.md
# Conditional Branch and Skip Resolver

This block settles the control-flow outcome of a conditional instruction in a small 8-bit core. The decoder presents one request per cycle. The request carries a kind (a branch on any single status flag, a signed-compare branch, an unsigned-compare branch, or a skip on a tested register bit), a polarity bit, a 7-bit relative offset, the current program counter, the status byte, the tested bit, and a flag that says whether the instruction after the current one is two words long.

One clock later the block returns three results. The first says whether the branch or skip is taken. The second is the program counter of the next instruction. The third is the number of cycles the instruction costs. The sequencer uses the cycle count to stall fetch and uses the new counter value to redirect it. The registered results hold their values while no request arrives.

Top module: `brskip_unit`

## Requirements
- R1: While reset is asserted and after its release, before any request, res_valid, taken, pc_next and cycles are all zero.
- R2: res_valid is high in exactly the cycle after a cycle in which req_valid was high, and the results in that cycle belong to that request.
- R3: For req_kind 0 (flag branch), taken is 1 exactly when bit flag_sel of sreg equals polarity. Polarity 1 means branch-if-set and polarity 0 means branch-if-clear. All eight bit indices are valid.
- R4: For req_kind 1 (signed compare), taken is 1 exactly when (sreg[2] XOR sreg[3]) equals polarity. Bit 2 is the negative flag and bit 3 is the overflow flag. Polarity 1 selects less-than and polarity 0 selects greater-or-equal.
- R5: For req_kind 2 (unsigned compare), taken is 1 exactly when sreg[0] equals polarity. Bit 0 is the carry flag. Polarity 1 selects lower and polarity 0 selects same-or-higher.
- R6: For req_kind 3 (skip), taken is 1 exactly when test_bit equals polarity.
- R7: A taken branch gives pc_next = pc_cur + sign-extended rel_offset + 1, taken modulo 2^PC_W.
- R8: An untaken branch or skip gives pc_next = pc_cur + 1, modulo 2^PC_W.
- R9: A taken skip gives pc_next = pc_cur + 2 when next_two_word is 0, and pc_cur + 3 when it is 1, modulo 2^PC_W.
- R10: A branch of any of the three branch kinds reports cycles = 1 when it is not taken and 2 when it is taken.
- R11: A skip reports cycles = 1 when it is not taken, 2 when it is taken over a one-word instruction, and 3 when it is taken over a two-word instruction.
- R12: In a cycle after one with req_valid low, taken, pc_next and cycles keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 flag branch, 1 signed, 2 unsigned, 3 skip |
| flag_sel | input | $clog2(SR_W) | Status bit index for a flag branch |
| polarity | input | 1 | Condition level that makes the instruction taken |
| rel_offset | input | OFS_W | Two's-complement branch displacement |
| pc_cur | input | PC_W | Program counter of the current instruction |
| sreg | input | SR_W | Status byte |
| test_bit | input | 1 | Register bit tested by a skip |
| next_two_word | input | 1 | The following instruction is two words long |
| res_valid | output | 1 | The results belong to the previous cycle's request |
| taken | output | 1 | The branch or skip is taken |
| pc_next | output | PC_W | Address of the next instruction |
| cycles | output | 2 | Cycle cost of the instruction |

## Verification
The bench builds the block with PC_W = 10, OFS_W = 7 and SR_W = 8. With these values the counter wraps at 1023, so a forward branch from the top of memory and a backward branch from near zero both cross the wrap. Both offset extremes, -64 and +63, can be reached, and so can a two-word skip that starts at 1022. The bench sweeps all eight flag indices with both polarities, all four combinations of the negative and overflow flags, and both carry levels. Idle cycles with changing inputs sit between requests.

// File: rtl/brskip_pkg.sv
package brskip_pkg;

  typedef enum logic [1:0] {
    KIND_FLAG     = 2'd0,
    KIND_SIGNED   = 2'd1,
    KIND_UNSIGNED = 2'd2,
    KIND_SKIP     = 2'd3
  } br_kind_e;

  // Status byte bit positions the compare kinds depend on
  localparam int unsigned SR_CARRY = 0;
  localparam int unsigned SR_NEG   = 2;
  localparam int unsigned SR_OVF   = 3;

  localparam int unsigned COST_W = 2;
  typedef logic [COST_W-1:0] cost_t;

  localparam cost_t COST_ONE   = 2'd1;
  localparam cost_t COST_TWO   = 2'd2;
  localparam cost_t COST_THREE = 2'd3;

endpackage

// File: rtl/brskip_cond.sv
module brskip_cond
  import brskip_pkg::*;
#(
  parameter int unsigned SR_W  = 8,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input  br_kind_e           kind,
  input  logic [SR_W-1:0]    sreg,
  input  logic [SEL_W-1:0]   sel,
  input  logic               pol,
  input  logic               tbit,
  output logic               take
);

  logic level;

  // Select the condition level for the request kind
  always_comb begin
    unique case (kind)
      KIND_FLAG:     level = sreg[sel];
      KIND_SIGNED:   level = sreg[SR_NEG] ^ sreg[SR_OVF];
      KIND_UNSIGNED: level = sreg[SR_CARRY];
      KIND_SKIP:     level = tbit;
      default:       level = 1'b0;
    endcase
  end

  // Polarity gives the level at which the instruction is taken
  assign take = ~(level ^ pol);

endmodule

// File: rtl/brskip_target.sv
module brskip_target
  import brskip_pkg::*;
#(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFS_W = 7
) (
  input  br_kind_e          kind,
  input  logic              take,
  input  logic              two_word,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFS_W-1:0]  ofs,
  output logic [PC_W-1:0]   pc_nxt
);

  localparam int unsigned EXT_W = PC_W - OFS_W;
  localparam logic [PC_W-1:0] STEP_ONE   = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_TWO   = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_THREE = PC_W'(3);

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] br_dest;
  logic [PC_W-1:0] skip_step;
  logic [PC_W-1:0] seq_dest;
  logic [PC_W-1:0] skip_dest;

  // The displacement is sign-extended to the counter width
  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    end else begin : g_noext
      assign ofs_ext = ofs[PC_W-1:0];
    end
  endgenerate

  // The three destinations are computed in parallel and then selected
  assign br_dest   = pc + ofs_ext + STEP_ONE;
  assign seq_dest  = pc + STEP_ONE;
  assign skip_step = two_word ? STEP_THREE : STEP_TWO;
  assign skip_dest = pc + skip_step;

  always_comb begin
    if (!take) begin
      pc_nxt = seq_dest;
    end else if (kind == KIND_SKIP) begin
      pc_nxt = skip_dest;
    end else begin
      pc_nxt = br_dest;
    end
  end

endmodule

// File: rtl/brskip_cost.sv
module brskip_cost
  import brskip_pkg::*;
(
  input  br_kind_e  kind,
  input  logic      take,
  input  logic      two_word,
  output cost_t     cyc
);

  always_comb begin
    if (!take) begin
      cyc = COST_ONE;
    end else if (kind == KIND_SKIP) begin
      cyc = two_word ? COST_THREE : COST_TWO;
    end else begin
      cyc = COST_TWO;
    end
  end

endmodule

// File: rtl/brskip_unit.sv
module brskip_unit
  import brskip_pkg::*;
#(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFS_W = 7,
  parameter int unsigned SR_W  = 8,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SEL_W-1:0]  flag_sel,
  input  logic              polarity,
  input  logic [OFS_W-1:0]  rel_offset,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [SR_W-1:0]   sreg,
  input  logic              test_bit,
  input  logic              next_two_word,
  output logic              res_valid,
  output logic              taken,
  output logic [PC_W-1:0]   pc_next,
  output logic [1:0]        cycles
);

  br_kind_e        kind;
  logic            take_c;
  logic [PC_W-1:0] pc_c;
  cost_t           cyc_c;

  logic            valid_q, valid_d;
  logic            taken_q, taken_d;
  logic [PC_W-1:0] pc_q,    pc_d;
  cost_t           cyc_q,   cyc_d;

  assign kind = br_kind_e'(req_kind);

  brskip_cond #(.SR_W(SR_W)) u_cond (
    .kind (kind),
    .sreg (sreg),
    .sel  (flag_sel),
    .pol  (polarity),
    .tbit (test_bit),
    .take (take_c)
  );

  brskip_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
    .kind     (kind),
    .take     (take_c),
    .two_word (next_two_word),
    .pc       (pc_cur),
    .ofs      (rel_offset),
    .pc_nxt   (pc_c)
  );

  brskip_cost u_cost (
    .kind     (kind),
    .take     (take_c),
    .two_word (next_two_word),
    .cyc      (cyc_c)
  );

  // Next-state: capture on a request, hold otherwise
  always_comb begin
    valid_d = req_valid;
    taken_d = taken_q;
    pc_d    = pc_q;
    cyc_d   = cyc_q;
    if (req_valid) begin
      taken_d = take_c;
      pc_d    = pc_c;
      cyc_d   = cyc_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      pc_q    <= '0;
      cyc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
      pc_q    <= pc_d;
      cyc_q   <= cyc_d;
    end
  end

  assign res_valid = valid_q;
  assign taken     = taken_q;
  assign pc_next   = pc_q;
  assign cycles    = cyc_q;

endmodule

// File: rtl/brskip_unit_chk.sv
module brskip_unit_chk #(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFS_W = 7,
  parameter int unsigned SR_W  = 8,
  localparam int unsigned SEL_W = $clog2(SR_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [SEL_W-1:0]  flag_sel,
  input logic              polarity,
  input logic [OFS_W-1:0]  rel_offset,
  input logic [PC_W-1:0]   pc_cur,
  input logic [SR_W-1:0]   sreg,
  input logic              test_bit,
  input logic              next_two_word,
  input logic              res_valid,
  input logic              taken,
  input logic [PC_W-1:0]   pc_next,
  input logic [1:0]        cycles
);

  localparam logic [PC_W-1:0] ONE   = PC_W'(1);
  localparam logic [PC_W-1:0] TWO   = PC_W'(2);
  localparam logic [PC_W-1:0] THREE = PC_W'(3);

  // R2
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  // R12
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(taken) && $stable(pc_next) && $stable(cycles)));

  // R4
  p_signed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |=>
      (taken == (($past(sreg[2]) ^ $past(sreg[3])) == $past(polarity))));

  // R6
  p_skip_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=>
      (taken == ($past(test_bit) == $past(polarity))));

  // R8
  p_untaken_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (taken || pc_next == ($past(pc_cur) + ONE)));

  // R9
  p_skip_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3 && test_bit == polarity) |=>
      (pc_next == ($past(pc_cur) + ($past(next_two_word) ? THREE : TWO))));

  // R10
  p_branch_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd3) |=> (cycles == (taken ? 2'd2 : 2'd1)));

  // R11
  p_skip_cost_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=>
      (cycles == (!taken ? 2'd1 : ($past(next_two_word) ? 2'd3 : 2'd2))));

endmodule

bind brskip_unit brskip_unit_chk #(
  .PC_W  (PC_W),
  .OFS_W (OFS_W),
  .SR_W  (SR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_kind      (req_kind),
  .flag_sel      (flag_sel),
  .polarity      (polarity),
  .rel_offset    (rel_offset),
  .pc_cur        (pc_cur),
  .sreg          (sreg),
  .test_bit      (test_bit),
  .next_two_word (next_two_word),
  .res_valid     (res_valid),
  .taken         (taken),
  .pc_next       (pc_next),
  .cycles        (cycles)
);

// File: tb/brskip_unit_tb_top.sv
`timescale 1ns/1ps
module brskip_unit_tb_top;

  localparam int PC_W  = 10;
  localparam int OFS_W = 7;
  localparam int SR_W  = 8;
  localparam int PC_MOD = 1 << PC_W;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [1:0]       req_kind;
  logic [2:0]       flag_sel;
  logic             polarity;
  logic [OFS_W-1:0] rel_offset;
  logic [PC_W-1:0]  pc_cur;
  logic [SR_W-1:0]  sreg;
  logic             test_bit;
  logic             next_two_word;
  logic             res_valid;
  logic             taken;
  logic [PC_W-1:0]  pc_next;
  logic [1:0]       cycles;

  int n_checks = 0;
  int n_errors = 0;

  int exp_taken = 0;
  int exp_pc    = 0;
  int exp_cyc   = 0;
  int exp_valid = 0;

  brskip_unit #(.PC_W(PC_W), .OFS_W(OFS_W), .SR_W(SR_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .flag_sel      (flag_sel),
    .polarity      (polarity),
    .rel_offset    (rel_offset),
    .pc_cur        (pc_cur),
    .sreg          (sreg),
    .test_bit      (test_bit),
    .next_two_word (next_two_word),
    .res_valid     (res_valid),
    .taken         (taken),
    .pc_next       (pc_next),
    .cycles        (cycles)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check("R2", "res_valid", int'(res_valid), exp_valid);
    check(req, "taken", int'(taken), exp_taken);
    check(req, "pc_next", int'(pc_next), exp_pc);
    check(req, "cycles", int'(cycles), exp_cyc);
  endtask

  // Reference model: one request, checked one clock later
  task automatic do_req(input int kind, input int sel, input int pol, input int ofs,
                        input int pc, input int sr, input int tb, input int two,
                        input string req);
    int level;
    int soff;
    req_valid     = 1'b1;
    req_kind      = 2'(kind);
    flag_sel      = 3'(sel);
    polarity      = 1'(pol);
    rel_offset    = OFS_W'(ofs);
    pc_cur        = PC_W'(pc);
    sreg          = SR_W'(sr);
    test_bit      = 1'(tb);
    next_two_word = 1'(two);
    case (kind)
      0: level = (sr >> sel) & 1;
      1: level = ((sr >> 2) & 1) ^ ((sr >> 3) & 1);
      2: level = sr & 1;
      default: level = tb;
    endcase
    exp_taken = (level == pol) ? 1 : 0;
    soff = (ofs >= 64) ? ofs - 128 : ofs;
    if (exp_taken == 0) begin
      exp_pc  = (pc + 1) % PC_MOD;
      exp_cyc = 1;
    end else if (kind == 3) begin
      exp_pc  = (pc + (two ? 3 : 2)) % PC_MOD;
      exp_cyc = two ? 3 : 2;
    end else begin
      exp_pc  = ((pc + soff + 1) % PC_MOD + PC_MOD) % PC_MOD;
      exp_cyc = 2;
    end
    exp_valid = 1;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic idle(input int junk);
    req_valid     = 1'b0;
    req_kind      = 2'(junk);
    flag_sel      = 3'(junk >> 1);
    polarity      = 1'(junk);
    rel_offset    = OFS_W'(junk * 7);
    pc_cur        = PC_W'(junk * 37);
    sreg          = SR_W'(~junk);
    test_bit      = 1'(junk >> 2);
    next_two_word = 1'(junk >> 3);
    exp_valid = 0;
    @(negedge clk);
    compare_all("R12");
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_kind = '0; flag_sel = '0; polarity = 1'b0;
    rel_offset = '0; pc_cur = '0; sreg = '0; test_bit = 1'b0; next_two_word = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R3: every flag index, both polarities, two status patterns
    for (int s = 0; s < 8; s++) begin
      do_req(0, s, 1, 5, 100, 8'hA5, 0, 0, "R3");
      do_req(0, s, 0, 5, 100, 8'hA5, 0, 0, "R3");
      do_req(0, s, 1, 9, 200, 8'h5A, 0, 0, "R3");
    end
    idle(3);

    // R4: all negative/overflow combinations
    for (int nv = 0; nv < 4; nv++) begin
      do_req(1, 0, 1, 3, 50, nv << 2, 0, 0, "R4");
      do_req(1, 0, 0, 3, 50, (nv << 2) | 8'hF3, 0, 0, "R4");
    end

    // R5: carry both ways
    do_req(2, 0, 1, 10, 300, 8'h01, 0, 0, "R5");
    do_req(2, 0, 1, 10, 300, 8'hFE, 0, 0, "R5");
    do_req(2, 0, 0, 10, 300, 8'h01, 0, 0, "R5");
    do_req(2, 0, 0, 10, 300, 8'hFE, 0, 0, "R5");
    idle(12);
    idle(5);

    // R6 R9 R11: skip outcomes and lengths
    for (int t = 0; t < 2; t++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          do_req(3, 0, p, 0, 400, 0, t, w, "R6_R9_R11");

    // R7: offsets at the extremes and across the wrap
    do_req(0, 1, 1, 7'h3F, 10, 8'h02, 0, 0, "R7");
    do_req(0, 1, 1, 7'h40, 100, 8'h02, 0, 0, "R7");
    do_req(0, 1, 1, 5, 1023, 8'h02, 0, 0, "R7");
    do_req(0, 1, 1, 7'h76, 3, 8'h02, 0, 0, "R7");
    do_req(1, 0, 0, 7'h7F, 0, 8'h00, 0, 0, "R7");

    // R8: untaken wraps too
    do_req(0, 1, 0, 20, 1023, 8'h02, 0, 0, "R8");
    do_req(3, 0, 1, 20, 1023, 8'h00, 0, 1, "R8");

    // R9: skip across the wrap
    do_req(3, 0, 1, 0, 1022, 8'h00, 1, 1, "R9");
    do_req(3, 0, 0, 0, 1023, 8'h00, 0, 0, "R9");

    // R10: branch cost after a long idle stretch
    for (int j = 0; j < 4; j++) idle(j * 9 + 1);
    do_req(2, 0, 0, 2, 600, 8'h00, 0, 1, "R10");
    do_req(2, 0, 0, 2, 600, 8'h01, 0, 1, "R10");
    idle(0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule